// File: doc/BRIEF.md
# Program-Bus Low-Byte Exchange Bridge

This block sits between a 16-bit data register file and a 24-bit program-memory port. Register values are only 16 bits wide, while program-memory words are 24 bits. An 8-bit side register, called the exchange byte here, carries the extra low bits. A wide read splits the memory word: the top 16 bits go to the register result and the bottom 8 bits are kept in the exchange byte. A wide write joins them again: the register supplies the top 16 bits and the exchange byte supplies the bottom 8.

Software can load the exchange byte from a register value before a write, and it can read the exchange byte back as a register value. A read from a program-bus region that is only 16 bits wide has no low byte, so the exchange byte is cleared. Accesses on the 16-bit data bus do not touch the exchange byte. Because of this, a wide read followed by a wide write copies a full 24-bit word through 16-bit registers with no loss.

Each operation takes one cycle. The write word appears in the same cycle as the operation. The read result is registered and shows one cycle later, and it holds until the next operation that produces a result.

Top module: `pmx_bridge`

## Requirements
- R1: After reset the exchange byte is 0x00 and `rd_result` is 0x0000.
- R2: A program-bus read (`op_kind`=2'b00, `op_pm`=1, `op_wide`=1) sets `rd_result` to `mem_rdata[23:8]` on the next cycle and loads the exchange byte with `mem_rdata[7:0]`.
- R3: A program-bus write (`op_kind`=2'b01, `op_pm`=1) drives `mem_wdata` = {`reg_wdata`, exchange byte} in the same cycle, whatever the value of `op_wide`.
- R4: A program-bus read of 16-bit-wide memory (`op_kind`=2'b00, `op_pm`=1, `op_wide`=0) sets `rd_result` to `mem_rdata[23:8]` and clears the exchange byte to 0x00.
- R5: An exchange load (`op_kind`=2'b10) stores `reg_wdata[7:0]` in the exchange byte and leaves `rd_result` unchanged.
- R6: An exchange read (`op_kind`=2'b11) sets `rd_result` on the next cycle to the exchange byte zero-extended to 16 bits.
- R7: A data-bus access (`op_pm`=0) leaves the exchange byte unchanged. A data-bus read sets `rd_result` to `mem_rdata[15:0]`. A data-bus write drives `mem_wdata` = {0x00, `reg_wdata`}.
- R8: When `op_valid`=0, `mem_wdata` is zero and neither the exchange byte nor `rd_result` changes. `mem_wdata` is also zero for every valid operation that is not a write.
- R9: A wide program-bus read followed by a program-bus write of the returned 16-bit result reproduces the original 24-bit word on `mem_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is present this cycle |
| op_kind | input | 2 | 00 memory read, 01 memory write, 10 exchange load, 11 exchange read |
| op_pm | input | 1 | 1 = program bus, 0 = 16-bit data bus |
| op_wide | input | 1 | 1 = the accessed program memory is 24 bits wide |
| mem_rdata | input | 24 | Read word returned by memory this cycle |
| reg_wdata | input | 16 | Source register value |
| mem_wdata | output | 24 | Write word towards memory |
| rd_result | output | 16 | Registered value for the destination register |

## Verification
The bench drives a long seeded random mix of all four operation kinds over both buses and both widths, with random data. This mix shows whether each path routes the correct byte lanes and whether the exchange byte survives the operations that must leave it alone. Directed sequences cover the remaining cases. A narrow read followed by an exchange read separates zero-fill from stale capture. A load followed by a program write separates the loaded byte from the last captured one. A memory-model copy of several words shows that a read and a write together keep all 24 bits. Idle cycles placed between operations show that no state moves without `op_valid`.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
    localparam int REG_W = 16;
    localparam int EXT_W = 8;
    localparam int MEM_W = REG_W + EXT_W;

    localparam logic [1:0] K_MRD  = 2'b00;
    localparam logic [1:0] K_MWR  = 2'b01;
    localparam logic [1:0] K_XLD  = 2'b10;
    localparam logic [1:0] K_XRD  = 2'b11;

    typedef struct packed {
        logic cap_wide;   // program read, wide memory: capture low byte
        logic cap_zero;   // program read, narrow memory: clear byte
        logic xr_load;    // explicit load from register value
        logic res_pm;     // result from upper lanes
        logic res_dm;     // result from lower lanes
        logic res_xr;     // result from exchange byte
        logic wr_pm;      // pack {reg, byte}
        logic wr_dm;      // pack {0, reg}
    } pmx_ctrl_t;
endpackage

// File: rtl/pmx_decode.sv
module pmx_decode
    import pmx_pkg::*;
(
    input  logic       op_valid,
    input  logic [1:0] op_kind,
    input  logic       op_pm,
    input  logic       op_wide,
    output pmx_ctrl_t  ctrl
);
    always_comb begin
        ctrl = '0;
        if (op_valid) begin
            unique case (op_kind)
                K_MRD: begin
                    ctrl.cap_wide = op_pm & op_wide;
                    ctrl.cap_zero = op_pm & ~op_wide;
                    ctrl.res_pm   = op_pm;
                    ctrl.res_dm   = ~op_pm;
                end
                K_MWR: begin
                    ctrl.wr_pm = op_pm;
                    ctrl.wr_dm = ~op_pm;
                end
                K_XLD: ctrl.xr_load = 1'b1;
                K_XRD: ctrl.res_xr  = 1'b1;
                default: ctrl = '0;
            endcase
        end
    end
endmodule

// File: rtl/pmx_xreg.sv
module pmx_xreg
    import pmx_pkg::*;
#(
    parameter int EW = EXT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pmx_ctrl_t     ctrl,
    input  logic [EW-1:0] rd_low,
    input  logic [EW-1:0] src_low,
    output logic [EW-1:0] xr_q
);
    typedef struct packed {
        logic [EW-1:0] xr;
    } xst_t;

    xst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl.cap_wide)      st_d.xr = rd_low;
        else if (ctrl.cap_zero) st_d.xr = '0;
        else if (ctrl.xr_load)  st_d.xr = src_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xr_q = st_q.xr;

    a_r2_capture_low: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.cap_wide |=> xr_q == $past(rd_low));
    a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.cap_zero |=> xr_q == '0);
    a_r5_load_low: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.xr_load |=> xr_q == $past(src_low));
    a_r7_dm_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.res_dm || ctrl.wr_dm) |=> $stable(xr_q));
    a_r8_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl == '0) |=> $stable(xr_q));
endmodule

// File: rtl/pmx_result.sv
module pmx_result
    import pmx_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int EW = EXT_W,
    localparam int MW = RW + EW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pmx_ctrl_t     ctrl,
    input  logic [MW-1:0] mem_rdata,
    input  logic [EW-1:0] xr_q,
    output logic [RW-1:0] rd_result
);
    typedef struct packed {
        logic [RW-1:0] res;
    } rst_t;

    rst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl.res_pm)      st_d.res = mem_rdata[MW-1:EW];
        else if (ctrl.res_dm) st_d.res = mem_rdata[RW-1:0];
        else if (ctrl.res_xr) st_d.res = {{(RW-EW){1'b0}}, xr_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_result = st_q.res;

    a_r2_upper_result: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.res_pm |=> rd_result == $past(mem_rdata[MW-1:EW]));
    a_r7_dm_result: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.res_dm |=> rd_result == $past(mem_rdata[RW-1:0]));
    a_r6_xr_result: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.res_xr |=> rd_result[EW-1:0] == $past(xr_q) && rd_result[RW-1:EW] == '0);
    a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.xr_load |=> $stable(rd_result));
endmodule

// File: rtl/pmx_pack.sv
module pmx_pack
    import pmx_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int EW = EXT_W,
    localparam int MW = RW + EW
) (
    input  pmx_ctrl_t     ctrl,
    input  logic [RW-1:0] reg_wdata,
    input  logic [EW-1:0] xr_q,
    output logic [MW-1:0] mem_wdata
);
    always_comb begin
        mem_wdata = '0;
        if (ctrl.wr_pm)      mem_wdata = {reg_wdata, xr_q};
        else if (ctrl.wr_dm) mem_wdata = {{EW{1'b0}}, reg_wdata};
    end
endmodule

// File: rtl/pmx_bridge.sv
module pmx_bridge
    import pmx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_kind,
    input  logic             op_pm,
    input  logic             op_wide,
    input  logic [MEM_W-1:0] mem_rdata,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [MEM_W-1:0] mem_wdata,
    output logic [REG_W-1:0] rd_result
);
    pmx_ctrl_t        ctrl;
    logic [EXT_W-1:0] xr_q;

    pmx_decode u_dec (
        .op_valid (op_valid),
        .op_kind  (op_kind),
        .op_pm    (op_pm),
        .op_wide  (op_wide),
        .ctrl     (ctrl)
    );

    pmx_xreg #(.EW(EXT_W)) u_xr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl),
        .rd_low  (mem_rdata[EXT_W-1:0]),
        .src_low (reg_wdata[EXT_W-1:0]),
        .xr_q    (xr_q)
    );

    pmx_result #(.RW(REG_W), .EW(EXT_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .mem_rdata (mem_rdata),
        .xr_q      (xr_q),
        .rd_result (rd_result)
    );

    pmx_pack #(.RW(REG_W), .EW(EXT_W)) u_pack (
        .ctrl      (ctrl),
        .reg_wdata (reg_wdata),
        .xr_q      (xr_q),
        .mem_wdata (mem_wdata)
    );

    a_r3_pm_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == K_MWR && op_pm)
            |-> mem_wdata[MEM_W-1:EXT_W] == reg_wdata);
    a_r7_dm_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == K_MWR && !op_pm)
            |-> mem_wdata == {{EXT_W{1'b0}}, reg_wdata});
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> mem_wdata == '0 ##1 $stable(rd_result));
    a_r9_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == K_MRD && op_pm && op_wide)
            ##1 (op_valid && op_kind == K_MWR && op_pm && reg_wdata == rd_result)
            |-> mem_wdata == $past(mem_rdata));
endmodule

// File: tb/pmx_bridge_tb_top.sv
module pmx_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic        op_pm = 1'b0;
    logic        op_wide = 1'b0;
    logic [23:0] mem_rdata = '0;
    logic [15:0] reg_wdata = '0;
    logic [23:0] mem_wdata;
    logic [15:0] rd_result;

    int checks = 0;
    int failures = 0;
    logic [7:0]  m_xr = 8'h00;
    logic [15:0] m_res = 16'h0000;
    logic [23:0] mem_model [0:15];

    always #10 clk = ~clk;

    pmx_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_pm(op_pm), .op_wide(op_wide), .mem_rdata(mem_rdata),
        .reg_wdata(reg_wdata), .mem_wdata(mem_wdata), .rd_result(rd_result)
    );

    function automatic logic [23:0] exp_wdata(logic v, logic [1:0] k, logic pm,
                                              logic [15:0] w, logic [7:0] xr);
        if (!v || k != 2'b01) return 24'h0;
        return pm ? {w, xr} : {8'h00, w};
    endfunction

    function automatic logic [7:0] exp_xr(logic v, logic [1:0] k, logic pm, logic wide,
                                          logic [23:0] r, logic [15:0] w, logic [7:0] xr);
        if (!v) return xr;
        if (k == 2'b00 && pm) return wide ? r[7:0] : 8'h00;
        if (k == 2'b10) return w[7:0];
        return xr;
    endfunction

    function automatic logic [15:0] exp_res(logic v, logic [1:0] k, logic pm,
                                            logic [23:0] r, logic [7:0] xr, logic [15:0] res);
        if (!v) return res;
        if (k == 2'b00) return pm ? r[23:8] : r[15:0];
        if (k == 2'b11) return {8'h00, xr};
        return res;
    endfunction

    task automatic check24(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation: drive at negedge, check the write word, then the registered result.
    task automatic do_op(string req, logic v, logic [1:0] k, logic pm, logic wide,
                         logic [23:0] r, logic [15:0] w);
        @(negedge clk);
        op_valid = v; op_kind = k; op_pm = pm; op_wide = wide;
        mem_rdata = r; reg_wdata = w;
        #1;
        check24(req, mem_wdata, exp_wdata(v, k, pm, w, m_xr));
        m_res = exp_res(v, k, pm, r, m_xr, m_res);
        m_xr  = exp_xr(v, k, pm, wide, r, w, m_xr);
        @(posedge clk);
        #1;
        check16(req, rd_result, m_res);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        #1;
        check16("R1 reset result", rd_result, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: exchange byte reads back as zero after reset
        do_op("R1 reset xr", 1'b1, 2'b11, 1'b0, 1'b0, 24'h0, 16'h0);

        // R2 / R3: wide read then write
        do_op("R2 wide read", 1'b1, 2'b00, 1'b1, 1'b1, 24'hA1B2C3, 16'h0);
        do_op("R3 pm write", 1'b1, 2'b01, 1'b1, 1'b1, 24'h0, 16'h5566);
        do_op("R3 pm write narrow flag", 1'b1, 2'b01, 1'b1, 1'b0, 24'h0, 16'h7788);
        // R4: narrow read clears byte; observe via exchange read
        do_op("R4 narrow read", 1'b1, 2'b00, 1'b1, 1'b0, 24'h1234FF, 16'h0);
        do_op("R4 zero fill seen", 1'b1, 2'b11, 1'b0, 1'b0, 24'h0, 16'h0);
        // R5: load then program write and exchange read
        do_op("R5 load", 1'b1, 2'b10, 1'b0, 1'b0, 24'h0, 16'hBE5A);
        do_op("R5 load used", 1'b1, 2'b01, 1'b1, 1'b1, 24'h0, 16'h0F0F);
        do_op("R6 xr read", 1'b1, 2'b11, 1'b1, 1'b1, 24'hFFFFFF, 16'hFFFF);
        // R7: data bus leaves byte alone
        do_op("R7 dm read", 1'b1, 2'b00, 1'b0, 1'b1, 24'h99ABCD, 16'h0);
        do_op("R7 dm write", 1'b1, 2'b01, 1'b0, 1'b1, 24'h0, 16'hC0DE);
        do_op("R7 byte kept", 1'b1, 2'b11, 1'b0, 1'b0, 24'h0, 16'h0);
        // R8: idle with noisy inputs
        do_op("R8 idle", 1'b0, 2'b00, 1'b1, 1'b1, 24'h777777, 16'h1111);
        do_op("R8 idle write kind", 1'b0, 2'b01, 1'b1, 1'b1, 24'h0, 16'h2222);
        do_op("R8 byte kept", 1'b1, 2'b11, 1'b0, 1'b0, 24'h0, 16'h0);

        // R9: copy words through the register path using a memory model
        for (int i = 0; i < 16; i++) mem_model[i] = 24'($urandom);
        for (int i = 0; i < 8; i++) begin
            do_op("R9 copy read", 1'b1, 2'b00, 1'b1, 1'b1, mem_model[i], 16'h0);
            do_op("R9 copy write", 1'b1, 2'b01, 1'b1, 1'b1, 24'h0, rd_result);
            check24("R9 copy word", mem_wdata, mem_model[i]);
            mem_model[i + 8] = mem_wdata;
        end

        // Random mix: R2 R3 R4 R5 R6 R7 R8 checked by the model functions
        for (int n = 0; n < 600; n++) begin
            logic v;
            v = ($urandom % 8) != 0;
            do_op("R2-mix", v, 2'($urandom), 1'($urandom), 1'($urandom),
                  24'($urandom), 16'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule